// File: doc/BRIEF.md
# Branch and Loop Condition Evaluator

This block decides whether a conditional short branch or a counted loop branch is taken. A request presents either a 4-bit branch condition code or a 2-bit loop form, together with the arithmetic flags (carry, zero, sign, overflow, parity) and the 16-bit count register. One cycle later the block reports the decision. For the counted loop forms it also reports the decremented count and a write strobe, so the register file can store the new count.

Branch condition codes are arranged in complementary pairs. Each even code names a base condition, and the odd code next to it is that condition negated. The loop forms are a plain counted loop, a loop that also requires the zero flag set, a loop that also requires it clear, and a branch taken when the count is already zero. That last form leaves the count unchanged. The block never produces or changes any flag. Target address computation and instruction fetch belong to the surrounding pipeline.

Top module: `brc_unit`

## Requirements
- R1: Unsigned codes: 2 is taken when CF=1, 3 when CF=0, 6 when CF=1 or ZF=1, 7 when CF=0 and ZF=0.
- R2: Signed codes: 12 is taken when SF differs from OF, 13 when SF equals OF, 14 when SF differs from OF or ZF=1, 15 when ZF=0 and SF equals OF.
- R3: Single-flag codes: 0 is taken when OF=1, 1 when OF=0, 4 when ZF=1, 5 when ZF=0, 8 when SF=1, 9 when SF=0, 10 when PF=1, 11 when PF=0.
- R4: For every even code c and every flag pattern, code c+1 gives the opposite decision to code c.
- R5: Loop form 3 (branch on zero count) is taken exactly when count_in is 0. It leaves count_we low and returns count_in unchanged on count_out.
- R6: Loop form 0 returns count_in-1 modulo 2^16 on count_out with count_we high, and is taken when that new count is nonzero. An input count of 0 wraps to FFFFh and is taken.
- R7: Loop form 1 decrements and writes as in R6, and is taken only when the new count is nonzero and ZF=1.
- R8: Loop form 2 decrements and writes as in R6, and is taken only when the new count is nonzero and ZF=0.
- R9: done_q goes high for exactly the one cycle after a request is sampled, and count_we can only be high in that cycle. With no request, taken_q and count_out keep their last values.
- R10: During reset, done_q, taken_q, count_we and count_out are all 0.
- R11: A branch condition request (is_loop=0) leaves count_we low and returns count_in unchanged on count_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Evaluate the presented operands this cycle |
| is_loop | input | 1 | 1 selects a loop form, 0 selects a branch condition code |
| cond_code | input | 4 | Branch condition code (pairs, bit 0 negates) |
| loop_sel | input | 2 | Loop form: 0 plain, 1 while ZF=1, 2 while ZF=0, 3 zero-count branch |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| count_in | input | 16 | Current count register value |
| done_q | output | 1 | Decision valid (one cycle after request) |
| taken_q | output | 1 | Branch taken |
| count_out | output | 16 | New count value (or the unchanged count) |
| count_we | output | 1 | Write strobe for the new count |

## Verification
Every result is produced by a single register stage. done_q, taken_q, count_out and count_we therefore all reflect a request one clock edge after the edge that samples it. The bench drives each request on a falling edge and drops req_valid at the next falling edge, then reads the results at that same falling edge. By then exactly one rising edge has passed. An extra idle cycle after some requests confirms that the strobes fall after one cycle while the decision and count keep their values.

// File: rtl/brc_pkg.sv
package brc_pkg;

  localparam int unsigned COND_W  = 4;
  localparam int unsigned NUM_CC  = 1 << COND_W;
  localparam int unsigned NUM_BASE = NUM_CC / 2;
  localparam int unsigned LOOP_W  = 2;

  // Base condition index (cond_code[3:1]); odd codes negate the base.
  typedef enum logic [COND_W-2:0] {
    BASE_OVF   = 3'd0,
    BASE_CARRY = 3'd1,
    BASE_ZERO  = 3'd2,
    BASE_CZ    = 3'd3,
    BASE_SIGN  = 3'd4,
    BASE_PAR   = 3'd5,
    BASE_LESS  = 3'd6,
    BASE_LEQ   = 3'd7
  } base_e;

  typedef enum logic [LOOP_W-1:0] {
    LP_PLAIN = 2'd0,
    LP_EQ    = 2'd1,
    LP_NE    = 2'd2,
    LP_CXZ   = 2'd3
  } loop_e;

  typedef struct packed {
    logic pf;
    logic of;
    logic sf;
    logic zf;
    logic cf;
  } flags_t;

endpackage

// File: rtl/brc_flag_eval.sv
module brc_flag_eval
  import brc_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              hit_o
);

  logic [NUM_BASE-1:0] base;
  logic [NUM_CC-1:0]   all_cond;
  logic                lt;

  always_comb begin
    lt = flags_i.sf ^ flags_i.of;
    base = '0;
    base[BASE_OVF]   = flags_i.of;
    base[BASE_CARRY] = flags_i.cf;
    base[BASE_ZERO]  = flags_i.zf;
    base[BASE_CZ]    = flags_i.cf | flags_i.zf;
    base[BASE_SIGN]  = flags_i.sf;
    base[BASE_PAR]   = flags_i.pf;
    base[BASE_LESS]  = lt;
    base[BASE_LEQ]   = lt | flags_i.zf;
  end

  // Expand each base condition into its true / negated pair.
  for (genvar gi = 0; gi < NUM_CC; gi++) begin : g_pair
    if ((gi % 2) == 0) begin : g_pos
      assign all_cond[gi] = base[gi/2];
    end else begin : g_neg
      assign all_cond[gi] = ~base[gi/2];
    end
  end

  assign hit_o = all_cond[cond_i];

endmodule

// File: rtl/brc_count_eval.sv
module brc_count_eval
  import brc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [LOOP_W-1:0] sel_i,
  input  logic              zf_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              hit_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              wr_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] dec;
  logic             dec_nz;

  assign dec    = count_i - ONE;
  assign dec_nz = |dec;

  always_comb begin
    hit_o   = 1'b0;
    count_o = dec;
    wr_o    = 1'b1;
    unique case (loop_e'(sel_i))
      LP_PLAIN: hit_o = dec_nz;
      LP_EQ:    hit_o = dec_nz & zf_i;
      LP_NE:    hit_o = dec_nz & ~zf_i;
      LP_CXZ: begin
        hit_o   = ~|count_i;
        count_o = count_i;
        wr_o    = 1'b0;
      end
      default: hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              is_loop,
  input  logic [3:0]        cond_code,
  input  logic [1:0]        loop_sel,
  input  logic              flag_cf,
  input  logic              flag_zf,
  input  logic              flag_sf,
  input  logic              flag_of,
  input  logic              flag_pf,
  input  logic [CNT_W-1:0]  count_in,
  output logic              done_q,
  output logic              taken_q,
  output logic [CNT_W-1:0]  count_out,
  output logic              count_we
);

  flags_t           flags;
  logic             jump_hit;
  logic             loop_hit;
  logic             loop_wr;
  logic [CNT_W-1:0] loop_count;

  logic             done_d;
  logic             taken_d;
  logic [CNT_W-1:0] cnt_d;
  logic             we_d;
  logic             res_en;

  assign flags = '{pf: flag_pf, of: flag_of, sf: flag_sf, zf: flag_zf, cf: flag_cf};

  brc_flag_eval u_flag (
    .cond_i  (cond_code),
    .flags_i (flags),
    .hit_o   (jump_hit)
  );

  brc_count_eval #(.CNT_W(CNT_W)) u_count (
    .sel_i   (loop_sel),
    .zf_i    (flag_zf),
    .count_i (count_in),
    .hit_o   (loop_hit),
    .count_o (loop_count),
    .wr_o    (loop_wr)
  );

  // Next-state logic
  always_comb begin
    res_en  = req_valid;
    done_d  = req_valid;
    taken_d = is_loop ? loop_hit : jump_hit;
    cnt_d   = is_loop ? loop_count : count_in;
    we_d    = req_valid & is_loop & loop_wr;
  end

  // Strobes: every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      count_we <= 1'b0;
    end else begin
      done_q   <= done_d;
      count_we <= we_d;
    end
  end

  // Decision and count: loaded only on request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q   <= 1'b0;
      count_out <= '0;
    end else if (res_en) begin
      taken_q   <= taken_d;
      count_out <= cnt_d;
    end
  end

endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             is_loop,
  input logic [1:0]       loop_sel,
  input logic             flag_zf,
  input logic [CNT_W-1:0] count_in,
  input logic             done_q,
  input logic             taken_q,
  input logic [CNT_W-1:0] count_out,
  input logic             count_we
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_done_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (done_q == $past(req_valid)));

  assert_we_only_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count_we |-> done_q);

  assert_cxz_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req_valid && is_loop && (loop_sel == 2'd3)))
      |-> (!count_we && (taken_q == ($past(count_in) == '0)) && (count_out == $past(count_in))));

  assert_loop_decrements_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req_valid && is_loop && (loop_sel != 2'd3)))
      |-> (count_we && (count_out == CNT_W'($past(count_in) - CNT_W'(1)))));

  assert_loop_eq_needs_zf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && taken_q && $past(req_valid && is_loop && (loop_sel == 2'd1))) |-> $past(flag_zf));

  assert_loop_ne_needs_nzf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && taken_q && $past(req_valid && is_loop && (loop_sel == 2'd2))) |-> !$past(flag_zf));

  assert_jump_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req_valid && !is_loop)) |-> (!count_we && (count_out == $past(count_in))));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(req_valid)) |-> ($stable(taken_q) && $stable(count_out)));

endmodule

bind brc_unit brc_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .is_loop   (is_loop),
  .loop_sel  (loop_sel),
  .flag_zf   (flag_zf),
  .count_in  (count_in),
  .done_q    (done_q),
  .taken_q   (taken_q),
  .count_out (count_out),
  .count_we  (count_we)
);

// File: tb/brc_unit_bench.sv
`timescale 1ns/1ps
module brc_unit_bench;

  localparam int CNT_W = 16;
  localparam int WATCHDOG_CYC = 20000;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic             is_loop;
  logic [3:0]       cond_code;
  logic [1:0]       loop_sel;
  logic             flag_cf, flag_zf, flag_sf, flag_of, flag_pf;
  logic [CNT_W-1:0] count_in;
  logic             done_q, taken_q, count_we;
  logic [CNT_W-1:0] count_out;

  int n_vec;
  int n_bad;
  bit res [16][32];

  brc_unit #(.CNT_W(CNT_W)) u_brc_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_loop(is_loop),
    .cond_code(cond_code), .loop_sel(loop_sel),
    .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_sf(flag_sf),
    .flag_of(flag_of), .flag_pf(flag_pf), .count_in(count_in),
    .done_q(done_q), .taken_q(taken_q), .count_out(count_out), .count_we(count_we)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_jump(input int cc, input bit cf, zf, sf, of, pf);
    case (cc)
      0:  return of;
      1:  return !of;
      2:  return cf;
      3:  return !cf;
      4:  return zf;
      5:  return !zf;
      6:  return cf || zf;
      7:  return !cf && !zf;
      8:  return sf;
      9:  return !sf;
      10: return pf;
      11: return !pf;
      12: return sf != of;
      13: return sf == of;
      14: return (sf != of) || zf;
      default: return !zf && (sf == of);
    endcase
  endfunction

  function automatic string jump_req(input int cc);
    if (cc == 2 || cc == 3 || cc == 6 || cc == 7) return "R1";
    if (cc >= 12) return "R2";
    return "R3";
  endfunction

  function automatic logic [15:0] pick_count(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h0002;
      3: return 16'hFFFF;
      4: return 16'h8000;
      5: return 16'h8001;
      6: return 16'h7FFF;
      default: return 16'(k * 4099 + 3);
    endcase
  endfunction

  task automatic drive(input bit lp, input int cc, input int sel, input int f, input logic [15:0] cnt);
    @(negedge clk);
    req_valid = 1'b1;
    is_loop   = lp;
    cond_code = 4'(cc);
    loop_sel  = 2'(sel);
    {flag_pf, flag_of, flag_sf, flag_zf, flag_cf} = 5'(f);
    count_in  = cnt;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    is_loop = 1'b0;
    cond_code = '0;
    loop_sel = '0;
    {flag_pf, flag_of, flag_sf, flag_zf, flag_cf} = '0;
    count_in = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(done_q == 1'b0,   "R10 done", 32'(done_q), 0);
    check(taken_q == 1'b0,  "R10 taken", 32'(taken_q), 0);
    check(count_we == 1'b0, "R10 we", 32'(count_we), 0);
    check(count_out == '0,  "R10 count", 32'(count_out), 0);
    rst_n = 1'b1;

    // Full sweep of branch codes over all flag patterns (R1 R2 R3 R11)
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 32; f++) begin
        logic [15:0] cnt;
        bit e;
        cnt = 16'(cc * 4099 + f * 77 + 5);
        e = exp_jump(cc, f[0], f[1], f[2], f[3], f[4]);
        drive(1'b0, cc, 3 - (f % 4), f, cnt);
        res[cc][f] = taken_q;
        check(done_q == 1'b1, "R9 done", 32'(done_q), 1);
        check(taken_q == e, jump_req(cc), {cc[15:0], 11'd0, f[4:0]} ^ 32'(taken_q), {cc[15:0], 11'd0, f[4:0]} ^ 32'(e));
        check(count_we == 1'b0 && count_out == cnt, "R11 count untouched",
              {15'd0, count_we, count_out}, {16'd0, cnt});
      end
    end

    // R4 pairs negate each other
    for (int cc = 0; cc < 16; cc += 2) begin
      for (int f = 0; f < 32; f++) begin
        check(res[cc][f] != res[cc+1][f], "R4 pair negation", 32'(res[cc+1][f]), 32'(!res[cc][f]));
      end
    end

    // Loop forms (R5 R6 R7 R8)
    for (int sel = 0; sel < 4; sel++) begin
      for (int z = 0; z < 2; z++) begin
        for (int k = 0; k < 20; k++) begin
          logic [15:0] cnt;
          logic [15:0] nc;
          bit e;
          bit ew;
          string rq;
          cnt = pick_count(k);
          nc  = cnt - 16'd1;
          case (sel)
            0: begin e = (nc != 0);             ew = 1'b1; rq = "R6"; end
            1: begin e = (nc != 0) && (z == 1); ew = 1'b1; rq = "R7"; end
            2: begin e = (nc != 0) && (z == 0); ew = 1'b1; rq = "R8"; end
            default: begin e = (cnt == 0); ew = 1'b0; nc = cnt; rq = "R5"; end
          endcase
          drive(1'b1, k % 16, sel, (z << 1) | (k % 2) | ((k % 4) << 2), cnt);
          check(taken_q == e, rq, 32'(taken_q), 32'(e));
          check(count_we == ew && count_out == nc, rq,
                {15'd0, count_we, count_out}, {15'd0, ew, nc});
          if (k == 3) begin
            // R9 one idle cycle: strobes fall, results hold
            @(negedge clk);
            check(done_q == 1'b0 && count_we == 1'b0, "R9 strobes idle",
                  {30'd0, done_q, count_we}, 0);
            check(taken_q == e && count_out == nc, "R9 hold",
                  {15'd0, taken_q, count_out}, {15'd0, e, nc});
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule